// File: doc/BRIEF.md
# Loop Counter Set-Instruction Executor

This block carries out the "set" class of 19-bit instruction words for a looping instruction engine. It holds the state that those words modify: a 6-bit outer loop counter, a 6-bit inner loop counter that can also be marked infinite, a 37-bit data latch, and two condition flags, A and B. Each accepted word changes exactly one of these targets. A one-hot major opcode picks the target. For the two counters, a sub-operation field then picks the source: the word's own immediate, the low bits of the current data-latch value, or a decrement.

Predicate evaluation is done by the surrounding logic, which presents the result on `predPass`. A word is executed only when it is strobed valid and its predicate passes. Its effect appears on the registered outputs after the next rising clock edge. A separate force input lets the loop-abort logic clear the outer counter and set the inner counter to one. This force overrides any word arriving in the same cycle. The block also provides an outer-counter-is-zero status, which the predicate logic uses.

Top module: `set_exec`

## Requirements
- R1: While `rstN` is low, the outer counter, inner counter, infinity marker, data latch and both flags are all zero, and `olcZero` is high.
- R2: If `insnValid` and `predPass` are not both high and `forceTorp` is low, no output changes at the next edge.
- R3: Major opcode `insnWord[18:15]` = 1000 targets the outer counter, and sub-operation `insnWord[14:12]` chooses what is loaded. Sub-operation 100 loads `insnWord[5:0]`, 010 loads `dlIn`, and 001 loads the counter minus one.
- R4: A decrement of the outer counter while it is zero leaves it at zero.
- R5: Major opcode 0100 targets the inner counter. Sub-operation 100 with `insnWord[6]`=0 loads `insnWord[5:0]` and clears the infinity marker. Sub-operation 100 with `insnWord[6]`=1 sets the infinity marker and leaves the counter value unchanged. Sub-operation 010 loads `dlIn` and clears the marker.
- R6: Major opcode 0010 loads the data latch. Bits 13:0 come from `insnWord[13:0]`, and all 23 upper bits are copies of `insnWord[14]`.
- R7: Major opcode 0001 updates both flags at once, using their old values. `insnWord[11:6]` selects the new A and `insnWord[5:0]` selects the new B. The selector codes are: 0 = A, 1 = not A, 2 = B, 3 = not B, 4 = zero, 5 = one.
- R8: A flag selector value of 6 to 63 leaves that flag unchanged.
- R9: When `forceTorp` is high, the next edge sets the outer counter to 0, the inner counter to 1 and the infinity marker to 0. Any word offered in the same cycle is discarded, so the data latch and flags hold.
- R10: `olcZero` is high exactly when the outer counter output is zero.
- R11: An accepted word has no effect in these cases: a major opcode that is not one of the four above, sub-operation codes other than those listed, and sub-operation 001 aimed at the inner counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| insnValid | input | 1 | A set word is present this cycle |
| insnWord | input | 19 | The set instruction word |
| predPass | input | 1 | The word's predicate evaluated true |
| forceTorp | input | 1 | Abort force: outer counter to 0, inner counter to 1 |
| dlIn | input | 6 | Low bits of the current data-latch value, the counter load source |
| olc | output | 6 | Outer loop counter |
| ilc | output | 6 | Inner loop counter value |
| ilcInf | output | 1 | Inner loop counter is infinite |
| dataLatch | output | 37 | Data latch |
| flagA | output | 1 | Condition flag A |
| flagB | output | 1 | Condition flag B |
| olcZero | output | 1 | Outer loop counter equals zero |

## Verification
The properties assume that `insnWord` and `dlIn` are meaningful only in a cycle where a word is accepted. They also assume that `forceTorp` may arrive together with any word, so every property about a word's effect is qualified with the force input being low. The stimulus drives every input only at the falling clock edge. It changes `insnWord` and `dlIn` freely even when the valid strobe or the predicate is low, so the hold property is tested against inputs that actually move. The random phase mostly draws legal one-hot opcodes but also mixes in illegal opcodes, undefined selectors and force pulses, so that the priority cases occur alongside the normal ones.

// File: rtl/set_exec_pkg.sv
package set_exec_pkg;

  localparam int INSN_W   = 19;
  localparam int OP_HI    = 18;
  localparam int OP_LO    = 15;
  localparam int SUB_HI   = 14;
  localparam int SUB_LO   = 12;
  localparam int IMM_W    = 6;
  localparam int INF_BIT  = 6;
  localparam int DLIMM_W  = 14;
  localparam int FILL_BIT = 14;
  localparam int SEL_W    = 6;
  localparam int FIELD_W  = SUB_HI + 1;

  localparam logic [3:0] OP_OLC  = 4'b1000;
  localparam logic [3:0] OP_ILC  = 4'b0100;
  localparam logic [3:0] OP_DL   = 4'b0010;
  localparam logic [3:0] OP_FLAG = 4'b0001;

  localparam logic [2:0] SUB_IMM = 3'b100;
  localparam logic [2:0] SUB_DL  = 3'b010;
  localparam logic [2:0] SUB_DEC = 3'b001;

  typedef enum logic [SEL_W-1:0] {
    SEL_A    = 6'd0,
    SEL_NA   = 6'd1,
    SEL_B    = 6'd2,
    SEL_NB   = 6'd3,
    SEL_ZERO = 6'd4,
    SEL_ONE  = 6'd5
  } flagSel_e;

  typedef struct packed {
    logic torp;
    logic olcImm;
    logic olcDl;
    logic olcDec;
    logic ilcImm;
    logic ilcInf;
    logic ilcDl;
    logic dlLoad;
    logic flagUpd;
  } strobe_t;

  function automatic logic pickFlag(logic [SEL_W-1:0] sel, logic curA,
                                    logic curB, logic keep);
    logic res;
    case (sel)
      SEL_A:    res = curA;
      SEL_NA:   res = ~curA;
      SEL_B:    res = curB;
      SEL_NB:   res = ~curB;
      SEL_ZERO: res = 1'b0;
      SEL_ONE:  res = 1'b1;
      default:  res = keep;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/set_exec_ctrl.sv
module set_exec_ctrl
  import set_exec_pkg::*;
(
  input  logic                    insnValid,
  input  logic                    predPass,
  input  logic                    forceTorp,
  input  logic [OP_HI-SUB_LO:0]   opSub,
  input  logic                    infSel,
  output strobe_t                 strb
);

  logic [3:0] majorOp;
  logic [2:0] subOp;
  logic       accept;

  assign majorOp = opSub[OP_HI-SUB_LO -: 4];
  assign subOp   = opSub[SUB_HI-SUB_LO:0];
  assign accept  = insnValid & predPass & ~forceTorp;

  always_comb begin
    strb      = '0;
    strb.torp = forceTorp;
    if (accept) begin
      case (majorOp)
        OP_OLC: begin
          strb.olcImm = (subOp == SUB_IMM);
          strb.olcDl  = (subOp == SUB_DL);
          strb.olcDec = (subOp == SUB_DEC);
        end
        OP_ILC: begin
          strb.ilcImm = (subOp == SUB_IMM) & ~infSel;
          strb.ilcInf = (subOp == SUB_IMM) & infSel;
          strb.ilcDl  = (subOp == SUB_DL);
        end
        OP_DL:   strb.dlLoad  = 1'b1;
        OP_FLAG: strb.flagUpd = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/set_exec_dp.sv
module set_exec_dp
  import set_exec_pkg::*;
#(
  parameter int LC_W = 6,
  parameter int DL_W = 37
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [FIELD_W-1:0] fieldBits,
  input  logic [LC_W-1:0]    dlIn,
  output logic [LC_W-1:0]    olc,
  output logic [LC_W-1:0]    ilc,
  output logic               ilcInf,
  output logic [DL_W-1:0]    dataLatch,
  output logic [1:0]         flagQ,
  output logic               olcZero
);

  localparam int FILL_N = DL_W - DLIMM_W;
  localparam logic [LC_W-1:0] ILC_ON_TORP = LC_W'(1);

  logic [LC_W-1:0] immVal;
  logic [DL_W-1:0] dlNext;
  logic [1:0]      flagNext;

  assign immVal  = LC_W'(fieldBits[IMM_W-1:0]);
  assign dlNext  = {{FILL_N{fieldBits[FILL_BIT]}}, fieldBits[DLIMM_W-1:0]};
  assign olcZero = (olc == '0);

  // index 1 is flag A (upper selector), index 0 is flag B (lower selector)
  for (genvar f = 0; f < 2; f++) begin : g_flag
    assign flagNext[f] = pickFlag(fieldBits[f*SEL_W +: SEL_W],
                                  flagQ[1], flagQ[0], flagQ[f]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      olc <= '0;
    end else if (strb.torp) begin
      olc <= '0;
    end else if (strb.olcImm) begin
      olc <= immVal;
    end else if (strb.olcDl) begin
      olc <= dlIn;
    end else if (strb.olcDec && !olcZero) begin
      olc <= olc - LC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ilc    <= '0;
      ilcInf <= 1'b0;
    end else if (strb.torp) begin
      ilc    <= ILC_ON_TORP;
      ilcInf <= 1'b0;
    end else if (strb.ilcImm) begin
      ilc    <= immVal;
      ilcInf <= 1'b0;
    end else if (strb.ilcDl) begin
      ilc    <= dlIn;
      ilcInf <= 1'b0;
    end else if (strb.ilcInf) begin
      ilcInf <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataLatch <= '0;
    end else if (strb.dlLoad) begin
      dataLatch <= dlNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
    end else if (strb.flagUpd) begin
      flagQ <= flagNext;
    end
  end

endmodule

// File: rtl/set_exec.sv
module set_exec
  import set_exec_pkg::*;
#(
  parameter int LC_W = 6,
  parameter int DL_W = 37
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insnValid,
  input  logic [INSN_W-1:0] insnWord,
  input  logic              predPass,
  input  logic              forceTorp,
  input  logic [LC_W-1:0]   dlIn,
  output logic [LC_W-1:0]   olc,
  output logic [LC_W-1:0]   ilc,
  output logic              ilcInf,
  output logic [DL_W-1:0]   dataLatch,
  output logic              flagA,
  output logic              flagB,
  output logic              olcZero
);

  strobe_t    strb;
  logic [1:0] flagQ;

  set_exec_ctrl u_ctrl (
    .insnValid (insnValid),
    .predPass  (predPass),
    .forceTorp (forceTorp),
    .opSub     (insnWord[OP_HI:SUB_LO]),
    .infSel    (insnWord[INF_BIT]),
    .strb      (strb)
  );

  set_exec_dp #(.LC_W(LC_W), .DL_W(DL_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .fieldBits (insnWord[FIELD_W-1:0]),
    .dlIn      (dlIn),
    .olc       (olc),
    .ilc       (ilc),
    .ilcInf    (ilcInf),
    .dataLatch (dataLatch),
    .flagQ     (flagQ),
    .olcZero   (olcZero)
  );

  assign flagA = flagQ[1];
  assign flagB = flagQ[0];

endmodule

// File: rtl/set_exec_chk.sv
module set_exec_chk
  import set_exec_pkg::*;
#(
  parameter int LC_W = 6,
  parameter int DL_W = 37
) (
  input logic              clk,
  input logic              rstN,
  input logic              insnValid,
  input logic [INSN_W-1:0] insnWord,
  input logic              predPass,
  input logic              forceTorp,
  input logic [LC_W-1:0]   olc,
  input logic [LC_W-1:0]   ilc,
  input logic              ilcInf,
  input logic [DL_W-1:0]   dataLatch,
  input logic              olcZero
);

  localparam int FILL_N = DL_W - DLIMM_W;

  logic take;
  assign take = insnValid & predPass & ~forceTorp;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!(insnValid && predPass) && !forceTorp) |=>
      ($stable(olc) && $stable(ilc) && $stable(ilcInf) && $stable(dataLatch)));

  p_dec_floor_r4: assert property (@(posedge clk) disable iff (!rstN)
    (take && insnWord[OP_HI:SUB_LO] == 7'b1000001 && olcZero) |=> olcZero);

  p_inf_mark_r5: assert property (@(posedge clk) disable iff (!rstN)
    (take && insnWord[OP_HI:SUB_LO] == 7'b0100100 && insnWord[INF_BIT])
      |=> (ilcInf && $stable(ilc)));

  p_dl_fill_r6: assert property (@(posedge clk) disable iff (!rstN)
    (take && insnWord[OP_HI:OP_LO] == OP_DL) |=>
      (dataLatch == {{FILL_N{$past(insnWord[FILL_BIT])}},
                     $past(insnWord[DLIMM_W-1:0])}));

  p_torp_r9: assert property (@(posedge clk) disable iff (!rstN)
    forceTorp |=> (olc == '0 && ilc == LC_W'(1) && !ilcInf && $stable(dataLatch)));

endmodule

bind set_exec set_exec_chk #(.LC_W(LC_W), .DL_W(DL_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .insnValid (insnValid),
  .insnWord  (insnWord),
  .predPass  (predPass),
  .forceTorp (forceTorp),
  .olc       (olc),
  .ilc       (ilc),
  .ilcInf    (ilcInf),
  .dataLatch (dataLatch),
  .olcZero   (olcZero)
);

// File: tb/set_exec_tb.sv
`timescale 1ns/1ps
module set_exec_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        insnValid;
  logic [18:0] insnWord;
  logic        predPass;
  logic        forceTorp;
  logic [5:0]  dlIn;
  logic [5:0]  olc;
  logic [5:0]  ilc;
  logic        ilcInf;
  logic [36:0] dataLatch;
  logic        flagA;
  logic        flagB;
  logic        olcZero;

  int compared = 0;
  int mismatched = 0;

  int      mOlc, mIlc;
  bit      mInf, mA, mB;
  longint  mDl;
  string   mTag = "R1";

  always #2.5 clk = ~clk;

  set_exec u_dut (
    .clk(clk), .rstN(rstN), .insnValid(insnValid), .insnWord(insnWord),
    .predPass(predPass), .forceTorp(forceTorp), .dlIn(dlIn),
    .olc(olc), .ilc(ilc), .ilcInf(ilcInf), .dataLatch(dataLatch),
    .flagA(flagA), .flagB(flagB), .olcZero(olcZero)
  );

  function automatic bit selF(int s, bit a, bit b, bit old);
    case (s)
      0: return a;
      1: return !a;
      2: return b;
      3: return !b;
      4: return 1'b0;
      5: return 1'b1;
      default: return old;
    endcase
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    int op, sub, sa, sb;
    bit na, nb;
    if (!rstN) begin
      mOlc = 0; mIlc = 0; mInf = 0; mDl = 0; mA = 0; mB = 0; mTag = "R1";
    end else if (forceTorp) begin
      mOlc = 0; mIlc = 1; mInf = 0; mTag = "R9";
    end else if (insnValid && predPass) begin
      op  = int'(insnWord[18:15]);
      sub = int'(insnWord[14:12]);
      mTag = "R11";
      if (op == 8) begin
        if (sub == 4)      begin mOlc = int'(insnWord[5:0]); mTag = "R3"; end
        else if (sub == 2) begin mOlc = int'(dlIn); mTag = "R3"; end
        else if (sub == 1) begin
          if (mOlc == 0) mTag = "R4";
          else begin mOlc = mOlc - 1; mTag = "R3"; end
        end
      end else if (op == 4) begin
        if (sub == 4 && insnWord[6])  begin mInf = 1; mTag = "R5"; end
        else if (sub == 4)            begin mIlc = int'(insnWord[5:0]); mInf = 0; mTag = "R5"; end
        else if (sub == 2)            begin mIlc = int'(dlIn); mInf = 0; mTag = "R5"; end
      end else if (op == 2) begin
        mDl = longint'(insnWord[13:0]);
        if (insnWord[14]) mDl = mDl + 64'h1F_FFFF_C000;
        mTag = "R6";
      end else if (op == 1) begin
        sa = int'(insnWord[11:6]);
        sb = int'(insnWord[5:0]);
        na = selF(sa, mA, mB, mA);
        nb = selF(sb, mA, mB, mB);
        mA = na; mB = nb;
        mTag = (sa > 5 || sb > 5) ? "R8" : "R7";
      end
    end else begin
      mTag = "R2";
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      chk(mTag, "olc", longint'(olc), longint'(mOlc));
      chk(mTag, "ilc", longint'(ilc), longint'(mIlc));
      chk(mTag, "ilcInf", longint'(ilcInf), longint'(mInf));
      chk(mTag, "dataLatch", longint'(dataLatch), mDl);
      chk(mTag, "flagA", longint'(flagA), longint'(mA));
      chk(mTag, "flagB", longint'(flagB), longint'(mB));
      chk("R10", "olcZero", longint'(olcZero), longint'(mOlc == 0));
    end
  end

  task automatic step(bit v, bit p, bit f, logic [18:0] w, logic [5:0] d);
    insnValid = v; predPass = p; forceTorp = f; insnWord = w; dlIn = d;
    @(negedge clk);
  endtask

  function automatic logic [18:0] wOlc(logic [2:0] s, logic [5:0] imm);
    return {4'b1000, s, 6'd0, imm};
  endfunction
  function automatic logic [18:0] wIlc(logic [2:0] s, bit inf, logic [5:0] imm);
    return {4'b0100, s, 5'd0, inf, imm};
  endfunction
  function automatic logic [18:0] wDl(bit fill, logic [13:0] imm);
    return {4'b0010, fill, imm};
  endfunction
  function automatic logic [18:0] wFlg(logic [5:0] a, logic [5:0] b);
    return {4'b0001, 3'd0, a, b};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired, run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0; insnValid = 0; predPass = 0; forceTorp = 0; insnWord = '0; dlIn = '0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "olc", longint'(olc), 0);
    chk("R1", "ilc", longint'(ilc), 0);
    chk("R1", "ilcInf", longint'(ilcInf), 0);
    chk("R1", "dataLatch", longint'(dataLatch), 0);
    chk("R1", "flags", longint'({flagA, flagB}), 0);
    chk("R1", "olcZero", longint'(olcZero), 1);
    rstN = 1'b1;
    @(negedge clk);

    // R3 / R4: outer counter sources and saturating decrement
    step(1, 1, 0, wOlc(3'b100, 6'd2), 6'd9);
    step(1, 1, 0, wOlc(3'b001, 6'd0), 6'd0);
    step(1, 1, 0, wOlc(3'b001, 6'd0), 6'd0);
    step(1, 1, 0, wOlc(3'b001, 6'd0), 6'd0);
    step(1, 1, 0, wOlc(3'b010, 6'd1), 6'h3F);
    // R5: inner counter, infinity marker, data-latch source
    step(1, 1, 0, wIlc(3'b100, 0, 6'd9), 6'd0);
    step(1, 1, 0, wIlc(3'b100, 1, 6'd33), 6'd0);
    step(1, 1, 0, wIlc(3'b010, 0, 6'd0), 6'd17);
    // R11: illegal cases
    step(1, 1, 0, wIlc(3'b001, 0, 6'd4), 6'd5);
    step(1, 1, 0, {4'b1100, 15'h7FFF}, 6'd3);
    step(1, 1, 0, {4'b0000, 15'h1234}, 6'd3);
    step(1, 1, 0, wOlc(3'b111, 6'd7), 6'd7);
    // R6: data latch fill both ways
    step(1, 1, 0, wDl(1, 14'h2AAA), 6'd0);
    step(1, 1, 0, wDl(0, 14'h3FFF), 6'd0);
    // R7 / R8: flag selections
    step(1, 1, 0, wFlg(6'd5, 6'd4), 6'd0);
    step(1, 1, 0, wFlg(6'd2, 6'd0), 6'd0);
    step(1, 1, 0, wFlg(6'd1, 6'd3), 6'd0);
    step(1, 1, 0, wFlg(6'd63, 6'd5), 6'd0);
    step(1, 1, 0, wFlg(6'd4, 6'd6), 6'd0);
    // R2: strobe or predicate missing
    step(1, 0, 0, wOlc(3'b100, 6'd44), 6'd1);
    step(0, 1, 0, wDl(1, 14'h0001), 6'd1);
    // R9: force beats a word in the same cycle
    step(1, 1, 1, wDl(1, 14'h1111), 6'd2);
    step(1, 1, 1, wIlc(3'b100, 1, 6'd8), 6'd2);
    step(0, 0, 0, '0, 6'd0);

    for (int i = 0; i < 4000; i++) begin
      int pick;
      logic [18:0] w;
      pick = int'($urandom_range(0, 9));
      w = 19'($urandom);
      case (pick)
        0, 1: w = wOlc(3'($urandom_range(0, 7)), 6'($urandom));
        2:    w = wOlc(3'b001, 6'd0);
        3, 4: w = wIlc(3'($urandom_range(0, 7)), 1'($urandom), 6'($urandom));
        5:    w = wDl(1'($urandom), 14'($urandom));
        6, 7: w = wFlg(6'($urandom_range(0, 7)), 6'($urandom_range(0, 7)));
        default: ;
      endcase
      step(($urandom_range(0, 7) != 0), ($urandom_range(0, 5) != 0),
           ($urandom_range(0, 15) == 0), w, 6'($urandom));
    end

    step(0, 0, 0, '0, 6'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule